// File: doc/BRIEF.md
# Microprogrammed Run-of-Ones Detector

This block watches a serial bit stream and raises its single output once four consecutive 1s have been sampled. It is a strict Moore machine. Its behaviour lives in two constant lookup tables that are computed at elaboration. The transitions are not hand-written.

A small state register holds the count of the current run of 1s, from code 0 to code 4. The first table is indexed by the input bit joined with the state code, and it returns the next state code. The second table is indexed by the state code alone, and it returns the output bit. The output therefore reacts to a clock edge and never to the input directly.

Reset is asynchronous and active low. It is released through a two-flop synchronizer, so the machine starts counting cleanly after reset is removed.

Top module: `run_detect_top`

## Requirements
- R1: While `rst_n` is low, `detect` is 0, and it goes to 0 at once when `rst_n` falls, without waiting for a clock edge.
- R2: `detect` becomes 1 right after the rising edge that samples the fourth consecutive 1 on `din`.
- R3: `detect` stays 0 while the current run of 1s is shorter than four.
- R4: A 0 sampled on `din` returns the machine to its start state (code 000), so four new 1s are needed before `detect` rises again.
- R5: A run of more than four 1s holds `detect` at 1 until a 0 is sampled.
- R6: `detect` depends only on the registered state. A change on `din` between clock edges leaves `detect` unchanged until the next rising edge.
- R7: After `rst_n` rises, the first two rising edges are ignored, and counting begins on the third edge.
- R8: The state codes run 000, 001, 010, 011, 100 for run lengths 0 to 4. Only code 100 drives `detect` high, and the state register never holds 101, 110 or 111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| din | input | 1 | Serial input bit, sampled on each rising edge |
| detect | output | 1 | High while at least four consecutive 1s have been sampled |

## Verification
A wrong entry in the next-state table appears at `detect` within at most five clock edges of the pattern that reaches it. The effect is a rise that comes one edge early or late, a missing hold during a long run, or a failure to clear after a 0.

A wrong entry in the output table appears in the same cycle that the state is entered. The bench keeps an independent run counter and compares `detect` with it after every edge, so any divergence is reported on the edge where it first shows. Glitching `din` mid-cycle shows any combinational path from input to output. Releasing reset with `din` held at 1 shows a miscounted release delay.

// File: rtl/run_detect_pkg.sv
package run_detect_pkg;

  parameter int unsigned DEF_RUN_LEN = 4;

  // Next state code for a given state code and input bit.
  function automatic int unsigned ns_code(int unsigned st, bit inb, int unsigned run_len);
    if (!inb)            return 0;
    if (st < run_len)    return st + 1;
    if (st == run_len)   return run_len;
    return 0;            // unused codes fall back to start
  endfunction

  // Output bit for a given state code.
  function automatic bit out_code(int unsigned st, int unsigned run_len);
    return (st == run_len);
  endfunction

endpackage

// File: rtl/run_reset_sync.sv
module run_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_core_n = hold_q;
endmodule

// File: rtl/run_next_rom.sv
module run_next_rom
  import run_detect_pkg::*;
#(
  parameter int unsigned RUN_LEN = DEF_RUN_LEN,
  parameter int unsigned STATE_W = $clog2(RUN_LEN + 1)
) (
  input  logic               bit_in,
  input  logic [STATE_W-1:0] cur_state,
  output logic [STATE_W-1:0] nxt_state
);
  localparam int unsigned ADDR_W = STATE_W + 1;
  localparam int unsigned DEPTH  = 1 << ADDR_W;

  logic [STATE_W-1:0] table_w [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_word
    localparam int unsigned ST = a % (1 << STATE_W);
    localparam bit          IB = (a >> STATE_W) != 0;
    localparam int unsigned NX = ns_code(ST, IB, RUN_LEN);
    assign table_w[a] = NX[STATE_W-1:0];
  end

  assign nxt_state = table_w[{bit_in, cur_state}];
endmodule

// File: rtl/run_out_rom.sv
module run_out_rom
  import run_detect_pkg::*;
#(
  parameter int unsigned RUN_LEN = DEF_RUN_LEN,
  parameter int unsigned STATE_W = $clog2(RUN_LEN + 1)
) (
  input  logic [STATE_W-1:0] cur_state,
  output logic               out_bit
);
  localparam int unsigned DEPTH = 1 << STATE_W;

  logic table_w [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_word
    localparam bit OB = out_code(s, RUN_LEN);
    assign table_w[s] = OB;
  end

  assign out_bit = table_w[cur_state];
endmodule

// File: rtl/run_detect_top.sv
module run_detect_top
  import run_detect_pkg::*;
#(
  parameter int unsigned RUN_LEN = DEF_RUN_LEN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic detect
);
  localparam int unsigned STATE_W = $clog2(RUN_LEN + 1);

  logic               rst_core_n;
  logic [STATE_W-1:0] state_q;
  logic [STATE_W-1:0] state_d;
  logic               step_en;

  run_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  run_next_rom #(.RUN_LEN(RUN_LEN), .STATE_W(STATE_W)) u_next (
    .bit_in    (din),
    .cur_state (state_q),
    .nxt_state (state_d)
  );

  // The state advances only once reset has been released internally.
  always_comb begin
    step_en = rst_core_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
    end else if (!rst_core_n) begin
      state_q <= '0;
    end else if (step_en) begin
      state_q <= state_d;
    end
  end

  run_out_rom #(.RUN_LEN(RUN_LEN), .STATE_W(STATE_W)) u_out (
    .cur_state (state_q),
    .out_bit   (detect)
  );
endmodule

// File: rtl/run_detect_checker.sv
module run_detect_checker #(
  parameter int unsigned RUN_LEN = 4,
  parameter int unsigned STATE_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rst_core_n,
  input logic               din,
  input logic [STATE_W-1:0] state_q,
  input logic               detect
);
  // R1: reset holds the output low
  a_r1_reset_low: assert property (@(posedge clk) !rst_n |-> !detect);

  // R2: the fourth 1 raises the output on the next edge
  a_r2_fourth_one: assert property (@(posedge clk) disable iff (!rst_core_n)
    (state_q == STATE_W'(RUN_LEN - 1) && din) |=> detect);

  // R3: short runs keep the output low
  a_r3_short_low: assert property (@(posedge clk) disable iff (!rst_core_n)
    (state_q != STATE_W'(RUN_LEN)) |-> !detect);

  // R4: a 0 sends the machine back to start
  a_r4_zero_clears: assert property (@(posedge clk) disable iff (!rst_core_n)
    !din |=> (state_q == '0 && !detect));

  // R5: extra 1s hold the output
  a_r5_hold_high: assert property (@(posedge clk) disable iff (!rst_core_n)
    (detect && din) |=> detect);

  // R8: no unused code is ever entered
  a_r8_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    state_q <= STATE_W'(RUN_LEN));
endmodule

bind run_detect_top run_detect_checker #(.RUN_LEN(RUN_LEN), .STATE_W(STATE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_core_n (rst_core_n),
  .din        (din),
  .state_q    (state_q),
  .detect     (detect)
);

// File: tb/run_detect_top_bench.sv
`timescale 1ns/1ps
module run_detect_top_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic din = 1'b0;
  logic detect;

  int checks = 0;
  int errors = 0;
  int run_cnt = 0;   // model: current run of 1s, capped at four
  int skip = 2;      // model: edges still ignored after reset release

  always #4 clk = ~clk;   // 125 MHz

  run_detect_top u_run_detect_top (.clk(clk), .rst_n(rst_n), .din(din), .detect(detect));

  task automatic check(input logic exp, input string req);
    checks++;
    if (detect !== exp) begin
      errors++;
      $display("FAIL %s: detect=%b expected=%b at %0t", req, detect, exp, $time);
    end
  endtask

  // Drive one bit at a falling edge, let one rising edge pass, check at the next falling edge.
  task automatic step(input logic b, input string req);
    din = b;
    @(posedge clk);
    if (rst_n) begin
      if (skip > 0) skip--;
      else run_cnt = b ? ((run_cnt < 4) ? run_cnt + 1 : 4) : 0;
    end
    @(negedge clk);
    check(run_cnt == 4, req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(1'b0, "R1");
    run_cnt = 0;
    skip = 2;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_release();
    // R7: din held at 1 through release; edges 1-2 ignored, edges 3-6 count
    rst_n = 1'b0;
    din = 1'b1;
    @(negedge clk);
    check(1'b0, "R1");
    rst_n = 1'b1;
    run_cnt = 0;
    skip = 2;
    for (int i = 0; i < 5; i++) step(1'b1, "R7");
    check(1'b0, "R7");
    step(1'b1, "R7");
    check(1'b1, "R7");
  endtask

  task automatic t_basic();
    step(1'b0, "R4");
    for (int i = 0; i < 3; i++) step(1'b1, "R3");
    step(1'b1, "R2");
    check(1'b1, "R2");
    step(1'b0, "R4");
    check(1'b0, "R4");
  endtask

  task automatic t_break();
    for (int i = 0; i < 3; i++) step(1'b1, "R3");
    step(1'b0, "R4");
    for (int i = 0; i < 3; i++) step(1'b1, "R4");
    check(1'b0, "R4");
    step(1'b1, "R2");
    step(1'b0, "R4");
    step(1'b1, "R3");
    step(1'b0, "R4");
  endtask

  task automatic t_long_run();
    for (int i = 0; i < 10; i++) step(1'b1, "R5");
    check(1'b1, "R5");
    step(1'b0, "R4");
  endtask

  task automatic t_moore();
    for (int i = 0; i < 3; i++) step(1'b1, "R3");
    din = 1'b1;
    #2 check(1'b0, "R6");
    din = 1'b0;
    #1 din = 1'b1;
    step(1'b1, "R2");
    din = 1'b0;
    #2 check(1'b1, "R6");
    step(1'b0, "R6");
  endtask

  task automatic t_mid_reset();
    for (int i = 0; i < 4; i++) step(1'b1, "R2");
    check(1'b1, "R8");
    do_reset();
    din = 1'b1;
    for (int i = 0; i < 6; i++) step(1'b1, "R7");
    check(1'b1, "R7");
    step(1'b0, "R4");
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    check(1'b0, "R1");
    t_release();
    t_basic();
    t_break();
    t_long_run();
    t_moore();
    t_mid_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule